// File: doc/BRIEF.md
# Octal Storage Register with Bus Readback

This block is an 8-bit edge-triggered register on a shared bidirectional data bus. When its active-low enable is asserted, it captures the bus on each rising clock edge. If the active-low read strobe is asserted at the same time, it also drives its stored byte back onto that bus, so a bus master can read back what it wrote earlier. When enable is deasserted, the register ignores the bus and never drives it.

A separate output port presents the stored byte continuously. A run-time select chooses whether that port shows the byte as stored or bit-inverted. An active-low output enable can float the port. Floating the output port does not affect the register itself, so it can load new data or keep old data while the port is off.

An active-low clear forces the contents to zero at once, without waiting for a clock edge. While it is held, no edge can load. Enable is meant to change only in the high phase of the clock. A bound checker flags any enable change that happens while the clock is low.

Top module: `octal_readback_reg`

## Requirements
- R1: While `en_n` is 0 and `clr_n` is 1, each rising edge of `clk` copies the 8-bit value on `data_io` into the register.
- R2: While `en_n` is 0 and `rd_n` is 0, the block drives the stored byte onto `data_io`.
- R3: While `en_n` is 1, rising clock edges leave the stored byte unchanged, whatever is on `data_io`.
- R4: When `en_n` is 1 or `rd_n` is 1, the block releases `data_io` to high impedance, so the value an external master drives is what appears on the bus.
- R5: With `oe_n` at 0, `q` equals the stored byte when `true_sel` is 1, and its bitwise inverse when `true_sel` is 0.
- R6: With `oe_n` at 1, `q` is high impedance, and loading still works: a byte captured while the port is off appears on `q` once `oe_n` returns to 0.
- R7: `clr_n` at 0 sets every stored bit to 0 immediately, without a clock edge, and overrides loading while it stays low.
- R8: `en_n` may change only while `clk` is 1. A change during the low phase of `clk` is flagged as a violation.
- R9: A rising edge during readback (`en_n` = 0, `rd_n` = 0) reloads the register from its own driven value, so the stored byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| en_n | input | 1 | Load and readback enable, active low |
| rd_n | input | 1 | Readback strobe onto the data bus, active low |
| oe_n | input | 1 | Output port enable, active low |
| true_sel | input | 1 | Output polarity: 1 true, 0 inverted |
| data_io | inout | 8 | Shared data bus, captured in and read back out |
| q | output | 8 | Tri-state output of the stored byte, polarity selected |

## Verification
Bytes 00, FF, 01, 80, A5 and 5A are each loaded and then read at both polarities. This pattern exposes stuck bits, swapped bit positions, and an inversion applied to the wrong bits. Readback is tested with the external driver silent. A clock edge is let through during readback to show that the register reloads its own value. The release cases use a driver byte that differs from the stored one. If the block kept driving the bus, the observed value would show it, and a separate monitor also flags any overlap between the two drivers.

A byte is loaded while the output port is off, which separates a working internal load from one gated by the output enable. Clear is asserted mid-cycle and sampled before the next edge, so a synchronous clear would fail that check.

// File: rtl/obr_pkg.sv
package obr_pkg;

  localparam int unsigned OBR_WIDTH = 8;

  typedef enum logic [1:0] {
    BUS_IDLE    = 2'd0,
    BUS_LOAD    = 2'd1,
    BUS_LOAD_RB = 2'd2
  } bus_mode_e;

  function automatic bus_mode_e decode_mode(input logic en_n, input logic rd_n);
    if (en_n)      return BUS_IDLE;
    else if (rd_n) return BUS_LOAD;
    else           return BUS_LOAD_RB;
  endfunction

endpackage

// File: rtl/obr_ctrl.sv
module obr_ctrl
  import obr_pkg::*;
(
  input  logic      en_n,
  input  logic      rd_n,
  output bus_mode_e mode,
  output logic      load_en,
  output logic      bus_oe
);

  always_comb begin
    mode    = decode_mode(en_n, rd_n);
    load_en = 1'b0;
    bus_oe  = 1'b0;
    unique case (mode)
      BUS_LOAD:    load_en = 1'b1;
      BUS_LOAD_RB: begin
        load_en = 1'b1;
        bus_oe  = 1'b1;
      end
      default: begin
        load_en = 1'b0;
        bus_oe  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/obr_store.sv
module obr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (load_en) q_next = d;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_next;
  end

endmodule

// File: rtl/obr_out_stage.sv
module obr_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] stored,
  input  logic         true_sel,
  input  logic         oe_n,
  output wire  [W-1:0] q
);

  logic [W-1:0] shaped;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign shaped[i] = true_sel ? stored[i] : ~stored[i];
    assign q[i]      = oe_n ? 1'bz : shaped[i];
  end

endmodule

// File: rtl/octal_readback_reg.sv
module octal_readback_reg
  import obr_pkg::*;
#(
  parameter int unsigned W = OBR_WIDTH
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         en_n,
  input  logic         rd_n,
  input  logic         oe_n,
  input  logic         true_sel,
  inout  wire  [W-1:0] data_io,
  output wire  [W-1:0] q
);

  bus_mode_e    mode;
  logic         load_en;
  logic         bus_oe;
  logic [W-1:0] stored_q;

  obr_ctrl u_ctrl (
    .en_n    (en_n),
    .rd_n    (rd_n),
    .mode    (mode),
    .load_en (load_en),
    .bus_oe  (bus_oe)
  );

  obr_store #(.W(W)) u_store (
    .clk     (clk),
    .clr_n   (clr_n),
    .load_en (load_en),
    .d       (data_io),
    .q       (stored_q)
  );

  obr_out_stage #(.W(W)) u_out (
    .stored   (stored_q),
    .true_sel (true_sel),
    .oe_n     (oe_n),
    .q        (q)
  );

  // Readback driver: the register presents its own byte on the shared bus
  assign data_io = bus_oe ? stored_q : {W{1'bz}};

endmodule

// File: rtl/obr_checker.sv
module obr_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         clr_n,
  input logic         en_n,
  input logic         rd_n,
  input logic         oe_n,
  input logic         true_sel,
  input logic [W-1:0] data_io,
  input logic [W-1:0] q,
  input logic [W-1:0] stored,
  input logic         bus_oe
);

  logic en_at_fall;
  logic fall_seen;

  always_ff @(negedge clk or negedge clr_n) begin
    if (!clr_n) begin
      fall_seen  <= 1'b0;
      en_at_fall <= 1'b1;
    end else begin
      fall_seen  <= 1'b1;
      en_at_fall <= en_n;
    end
  end

  p_load_r1: assert property (@(posedge clk) disable iff (!clr_n)
    (!en_n && clr_n) |=> (stored == $past(data_io)))
    else $error("p_load_r1");

  p_readback_r2: assert property (@(posedge clk) disable iff (!clr_n)
    (!en_n && !rd_n) |-> (data_io == stored))
    else $error("p_readback_r2");

  p_hold_r3: assert property (@(posedge clk) disable iff (!clr_n)
    en_n |=> $stable(stored))
    else $error("p_hold_r3");

  p_release_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (en_n || rd_n) |-> !bus_oe)
    else $error("p_release_r4");

  p_true_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (!oe_n && true_sel) |-> (q == stored))
    else $error("p_true_r5");

  p_inv_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (!oe_n && !true_sel) |-> (q == ~stored))
    else $error("p_inv_r5");

  p_en_steady_low_r8: assert property (@(posedge clk) disable iff (!clr_n)
    fall_seen |-> (en_n == en_at_fall))
    else $error("p_en_steady_low_r8");

  p_selfload_r9: assert property (@(posedge clk) disable iff (!clr_n)
    (!en_n && !rd_n) |=> $stable(stored))
    else $error("p_selfload_r9");

  always @(negedge clk) begin
    if (!clr_n) begin
      p_clear_r7: assert (stored == '0) else $error("p_clear_r7");
    end
  end

endmodule

bind octal_readback_reg obr_checker #(.W(W)) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .en_n     (en_n),
  .rd_n     (rd_n),
  .oe_n     (oe_n),
  .true_sel (true_sel),
  .data_io  (data_io),
  .q        (q),
  .stored   (stored_q),
  .bus_oe   (bus_oe)
);

// File: tb/octal_readback_reg_test.sv
module octal_readback_reg_test;

  typedef struct {
    logic       on_bus;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       clr_n, en_n, rd_n, oe_n, true_sel;
  logic       ext_en;
  logic [7:0] ext_val;
  wire  [7:0] data_io;
  wire  [7:0] q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  sb_item_t sb[$];

  always #4 clk = ~clk;

  assign data_io = ext_en ? ext_val : 8'bz;

  octal_readback_reg uut (
    .clk(clk), .clr_n(clr_n), .en_n(en_n), .rd_n(rd_n), .oe_n(oe_n),
    .true_sel(true_sel), .data_io(data_io), .q(q)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_en(input logic v);
    if (en_n !== v) begin
      checks++;
      if (clk !== 1'b1) begin
        errors++;
        $display("FAIL R8: en_n changed with clk=%b, expected 1", clk);
      end
      en_n = v;
    end
  endtask

  task automatic expect_q(input logic [7:0] e, input string tag);
    sb.push_back('{on_bus: 1'b0, exp: e, tag: tag});
  endtask

  task automatic expect_bus(input logic [7:0] e, input string tag);
    sb.push_back('{on_bus: 1'b1, exp: e, tag: tag});
  endtask

  task automatic load(input logic [7:0] v);
    ext_en  = 1'b1;
    ext_val = v;
    set_en(1'b0);
    step();
    set_en(1'b1);
    ext_en = 1'b0;
  endtask

  // Monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    if (!en_n && !rd_n) begin
      checks++;
      if (ext_en) begin
        errors++;
        $display("FAIL R2: bus contention, external driver=%h with readback active, expected driver off",
                 ext_val);
      end
    end
    while (sb.size() > 0) begin
      sb_item_t it;
      logic [7:0] act;
      it  = sb.pop_front();
      act = it.on_bus ? data_io : q;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: %s actual=%h expected=%h", it.tag,
                 it.on_bus ? "data_io" : "q", act, it.exp);
      end
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [6];
    pats = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h5A};
    clr_n = 1'b0; en_n = 1'b1; rd_n = 1'b1; oe_n = 1'b0;
    true_sel = 1'b1; ext_en = 1'b0; ext_val = 8'h00;

    // Reset state, both polarities (R7, R5)
    step();
    expect_q(8'h00, "R7 reset");
    step();
    true_sel = 1'b0;
    expect_q(8'hFF, "R5 reset inverted");
    step();
    true_sel = 1'b1;
    clr_n = 1'b1;
    step();

    // Load patterns and read at both polarities (R1, R5)
    foreach (pats[i]) begin
      load(pats[i]);
      expect_q(pats[i], "R1 load");
      step();
      true_sel = 1'b0;
      expect_q(~pats[i], "R5 inverted");
      step();
      true_sel = 1'b1;
    end

    // Hold with enable high while bus shows other data (R3)
    ext_en = 1'b1; ext_val = 8'h3C;
    step();
    step();
    expect_q(8'h5A, "R3 hold");
    step();
    ext_en = 1'b0;

    // Readback, with an edge passing during it (R2, R9)
    rd_n = 1'b0;
    set_en(1'b0);
    expect_bus(8'h5A, "R2 readback");
    step();
    expect_bus(8'h5A, "R9 readback after edge");
    expect_q(8'h5A, "R9 contents kept");
    step();
    set_en(1'b1);
    rd_n = 1'b1;

    // Release with rd_n high: external value visible and loaded (R4, R1)
    ext_en = 1'b1; ext_val = 8'h0F;
    set_en(1'b0);
    expect_bus(8'h0F, "R4 released rd high");
    step();
    set_en(1'b1);
    ext_en = 1'b0;
    expect_q(8'h0F, "R1 load after release");
    step();

    // Release with en_n high while rd_n low (R4, R3)
    rd_n = 1'b0;
    ext_en = 1'b1; ext_val = 8'h96;
    expect_bus(8'h96, "R4 released en high");
    step();
    rd_n = 1'b1;
    ext_en = 1'b0;
    expect_q(8'h0F, "R3 no load en high");
    step();

    // Load while output port is off (R6)
    oe_n = 1'b1;
    load(8'hC3);
    step();
    oe_n = 1'b0;
    expect_q(8'hC3, "R6 load while off");
    step();

    // Asynchronous clear mid-cycle, overriding load (R7)
    ext_en = 1'b1; ext_val = 8'h77;
    set_en(1'b0);
    #1;
    clr_n = 1'b0;
    expect_q(8'h00, "R7 async clear");
    step();
    expect_q(8'h00, "R7 clear overrides load");
    step();
    set_en(1'b1);
    ext_en = 1'b0;
    clr_n = 1'b1;
    step();
    expect_q(8'h00, "R7 cleared contents held");
    step();
    step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule